// File: doc/BRIEF.md
# Fetch-Interposing Instruction Hardening Checker

This block sits between a processor's instruction fetch port and program memory, with no instruction cache between them. It watches every fetch. Instructions whose opcode is outside a configurable hardening set go to the processor unchanged. A hardened instruction is held back. In its place the block feeds the processor a five-word sequence. The sequence makes the processor store both source registers to a reserved checker data address, execute the original operation, and store the destination register to the same address. It then branches back to the instruction that follows the intercepted one.

The block also sits on the processor's data write path. Writes to the checker address go to the block and never reach data memory. The block recomputes the operation on the two captured operands with its own ALU and compares the answer with the result the processor stored. A mismatch sets an error flag that stays set until reset and pulses an interrupt request. A sequence fetch whose address does not follow the previous one is treated the same way. Neither the software nor the processor needs any change.

The instruction format used here has a 16-bit word: opcode in bits [15:12], destination register in [11:8], first source in [7:4], second source in [3:0]. A store is opcode 0xE with the register in [11:8] and an 8-bit data address in [7:0]. A branch is opcode 0xF with a 12-bit absolute target in [11:0]. Every instruction is one word long, so "next address" means address plus one.

Top module: `fetch_harden_checker`

## Requirements
- R1: When no sequence is active and the fetched opcode is not in the hardening set, `cpu_idata` equals `mem_idata` in the same cycle. `mem_iaddr` always equals `cpu_iaddr`.
- R2: When no sequence is active and the fetched word `mem_idata` has an opcode in the hardening set, `cpu_idata` in that cycle is the store word {0xE, src1 field, CHK_ADDR} and a sequence begins.
- R3: The next four fetches of the sequence return, in order: {0xE, src2 field, CHK_ADDR}; the intercepted word unchanged; {0xE, dst field, CHK_ADDR}; {0xF, intercepted address + 1}. These words do not depend on `mem_idata`.
- R4: After the branch word has been fetched, the block passes fetches through again as in R1 and R2.
- R5: Parameter HARDEN_MASK has one bit per opcode value. Bit n set means opcode n is hardened. The default hardens ADD (0x1, dst=src1+src2) and INC (0x3, dst=src1+1). Every other opcode passes through.
- R6: A data write to any address other than CHK_ADDR appears on `mem_dwe`/`mem_daddr`/`mem_dwdata` in the same cycle. A write to CHK_ADDR leaves `mem_dwe` low.
- R7: The first, second and third writes to CHK_ADDR after an interception are taken as src1, src2 and result. If the result equals the block's own computation of the intercepted opcode (wrapping at DW bits), `chk_err` stays low.
- R8: If the result differs, `chk_err` goes high on the clock edge that samples the third write. It stays high until reset, whatever happens afterwards.
- R9: `chk_irq` is high for exactly one cycle, in the cycle in which `chk_err` first goes high.
- R10: During a sequence, a fetch whose address is not the previous fetch address plus one sets `chk_err` and pulses `chk_irq` on that clock edge.
- R11: After reset, `chk_err` and `chk_irq` are low and no sequence is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_ifetch | input | 1 | Processor fetch strobe |
| cpu_iaddr | input | 12 | Processor fetch address |
| cpu_idata | output | 16 | Instruction word returned to the processor |
| mem_iaddr | output | 12 | Fetch address to program memory |
| mem_idata | input | 16 | Instruction word from program memory |
| cpu_dwe | input | 1 | Processor data write enable |
| cpu_daddr | input | 8 | Processor data write address |
| cpu_dwdata | input | DW | Processor data write value |
| mem_dwe | output | 1 | Data write enable to data memory |
| mem_daddr | output | 8 | Data write address to data memory |
| mem_dwdata | output | DW | Data write value to data memory |
| chk_err | output | 1 | Sticky hardening error |
| chk_irq | output | 1 | One-cycle interrupt request on first error |

## Verification
Fetch substitution and data-write filtering are combinational, so the bench drives each fetch or write just after a falling edge and checks `cpu_idata` and `mem_dwe` one time step later, before the next rising edge. The error flag and the interrupt are registered on the edge that samples the result write or the bad fetch. The bench therefore checks them right after the following falling edge, checks `chk_irq` low one cycle later, and checks `chk_err` again after further unrelated traffic. Expected sequence words and ALU results are built in the bench from the field layout and arithmetic given in the requirements. The bench sweeps every opcode and many operand pairs.

// File: rtl/ihc_pkg.sv
package ihc_pkg;
  localparam int IW  = 16;
  localparam int OPW = 4;
  localparam int AW  = IW - OPW;
  localparam int DAW = 8;
  localparam int NOPS = 1 << OPW;

  typedef logic [OPW-1:0] op_t;

  localparam op_t OP_ADD   = 4'h1;
  localparam op_t OP_SUB   = 4'h2;
  localparam op_t OP_INC   = 4'h3;
  localparam op_t OP_AND   = 4'h4;
  localparam op_t OP_OR    = 4'h5;
  localparam op_t OP_XOR   = 4'h6;
  localparam op_t OP_STORE = 4'hE;
  localparam op_t OP_BR    = 4'hF;

  function automatic logic [IW-1:0] mk_store(input logic [3:0] r, input logic [DAW-1:0] a);
    return {OP_STORE, r, a};
  endfunction

  function automatic logic [IW-1:0] mk_branch(input logic [AW-1:0] t);
    return {OP_BR, t};
  endfunction
endpackage

// File: rtl/ihc_fetch_seq.sv
module ihc_fetch_seq
  import ihc_pkg::*;
#(
  parameter logic [NOPS-1:0] HARDEN_MASK = 16'h000A,
  parameter logic [DAW-1:0]  CHK_ADDR    = 8'hF0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_ifetch,
  input  logic [AW-1:0] cpu_iaddr,
  input  logic [IW-1:0] mem_idata,
  output logic [IW-1:0] cpu_idata,
  output logic          start,
  output op_t           start_op,
  output logic          seq_fault
);
  logic          busy_q, busy_d;
  logic [2:0]    idx_q, idx_d;
  logic [AW-1:0] base_q, base_d, last_q, last_d;
  logic [IW-1:0] instr_q, instr_d;
  logic          is_hard, adv;

  assign is_hard  = HARDEN_MASK[mem_idata[IW-1 -: OPW]];
  assign start_op = mem_idata[IW-1 -: OPW];
  assign adv      = cpu_ifetch;

  always_comb begin
    busy_d    = busy_q;
    idx_d     = idx_q;
    base_d    = base_q;
    last_d    = last_q;
    instr_d   = instr_q;
    cpu_idata = mem_idata;
    start     = 1'b0;
    seq_fault = 1'b0;
    if (!busy_q) begin
      if (cpu_ifetch && is_hard) begin
        cpu_idata = mk_store(mem_idata[7:4], CHK_ADDR);
        start     = 1'b1;
        busy_d    = 1'b1;
        idx_d     = 3'd1;
        base_d    = cpu_iaddr;
        last_d    = cpu_iaddr;
        instr_d   = mem_idata;
      end
    end else if (cpu_ifetch) begin
      seq_fault = (cpu_iaddr != last_q + AW'(1));
      last_d    = cpu_iaddr;
      idx_d     = idx_q + 3'd1;
      case (idx_q)
        3'd1:    cpu_idata = mk_store(instr_q[3:0], CHK_ADDR);
        3'd2:    cpu_idata = instr_q;
        3'd3:    cpu_idata = mk_store(instr_q[11:8], CHK_ADDR);
        default: begin
          cpu_idata = mk_branch(base_q + AW'(1));
          busy_d    = 1'b0;
          idx_d     = 3'd0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      idx_q   <= 3'd0;
      base_q  <= '0;
      last_q  <= '0;
      instr_q <= '0;
    end else if (adv) begin
      busy_q  <= busy_d;
      idx_q   <= idx_d;
      base_q  <= base_d;
      last_q  <= last_d;
      instr_q <= instr_d;
    end
  end

  assert_slot_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (idx_q >= 3'd1 && idx_q <= 3'd4));
  assert_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy_q && idx_q == 3'd1));
  assert_resume_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && idx_q == 3'd4 && cpu_ifetch) |=> !busy_q);
endmodule

// File: rtl/ihc_capture.sv
module ihc_capture
  import ihc_pkg::*;
#(
  parameter int             DW       = 8,
  parameter logic [DAW-1:0] CHK_ADDR = 8'hF0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cpu_dwe,
  input  logic [DAW-1:0] cpu_daddr,
  input  logic [DW-1:0]  cpu_dwdata,
  input  logic           start,
  input  op_t            start_op,
  output logic           mem_dwe,
  output logic [DAW-1:0] mem_daddr,
  output logic [DW-1:0]  mem_dwdata,
  output logic           cmp_valid,
  output op_t            op_q,
  output logic [DW-1:0]  a_q,
  output logic [DW-1:0]  b_q
);
  logic          to_chk;
  logic [1:0]    slot_q, slot_d;
  op_t           op_d;
  logic [DW-1:0] a_d, b_d;
  logic          en;

  assign to_chk     = cpu_dwe && (cpu_daddr == CHK_ADDR);
  assign mem_dwe    = cpu_dwe && !to_chk;
  assign mem_daddr  = cpu_daddr;
  assign mem_dwdata = cpu_dwdata;
  assign cmp_valid  = to_chk && (slot_q == 2'd2);
  assign en         = start || to_chk;

  always_comb begin
    slot_d = slot_q;
    op_d   = op_q;
    a_d    = a_q;
    b_d    = b_q;
    if (start) begin
      slot_d = 2'd0;
      op_d   = start_op;
    end else if (to_chk) begin
      case (slot_q)
        2'd0:    begin a_d = cpu_dwdata; slot_d = 2'd1; end
        2'd1:    begin b_d = cpu_dwdata; slot_d = 2'd2; end
        2'd2:    slot_d = 2'd3;
        default: slot_d = 2'd3;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= 2'd3;
      op_q   <= '0;
      a_q    <= '0;
      b_q    <= '0;
    end else if (en) begin
      slot_q <= slot_d;
      op_q   <= op_d;
      a_q    <= a_d;
      b_q    <= b_d;
    end
  end

  assert_absorb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dwe |-> (mem_daddr != CHK_ADDR));
  assert_cmp_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !start) |=> (slot_q == 2'd3));
endmodule

// File: rtl/ihc_alu_cmp.sv
module ihc_alu_cmp
  import ihc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_valid,
  input  op_t           op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] res,
  input  logic          seq_fault,
  output logic          err_q,
  output logic          irq_q
);
  logic [DW-1:0] ref_v;
  logic          hit, err_d, irq_d;

  always_comb begin
    case (op)
      OP_ADD:  ref_v = a + b;
      OP_SUB:  ref_v = a - b;
      OP_INC:  ref_v = a + DW'(1);
      OP_AND:  ref_v = a & b;
      OP_OR:   ref_v = a | b;
      OP_XOR:  ref_v = a ^ b;
      default: ref_v = a;
    endcase
  end

  always_comb begin
    hit   = seq_fault || (cmp_valid && (ref_v != res));
    err_d = err_q || hit;
    irq_d = hit && !err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      err_q <= err_d;
      irq_q <= irq_d;
    end
  end

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  assert_irq_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (err_q && !$past(err_q)));
  assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
endmodule

// File: rtl/fetch_harden_checker.sv
module fetch_harden_checker
  import ihc_pkg::*;
#(
  parameter int               DW          = 8,
  parameter logic [NOPS-1:0]  HARDEN_MASK = 16'h000A,
  parameter logic [DAW-1:0]   CHK_ADDR    = 8'hF0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cpu_ifetch,
  input  logic [AW-1:0]  cpu_iaddr,
  output logic [IW-1:0]  cpu_idata,
  output logic [AW-1:0]  mem_iaddr,
  input  logic [IW-1:0]  mem_idata,
  input  logic           cpu_dwe,
  input  logic [DAW-1:0] cpu_daddr,
  input  logic [DW-1:0]  cpu_dwdata,
  output logic           mem_dwe,
  output logic [DAW-1:0] mem_daddr,
  output logic [DW-1:0]  mem_dwdata,
  output logic           chk_err,
  output logic           chk_irq
);
  logic [1:0]    rst_sync_q;
  logic          rst_i;
  logic          start, seq_fault, cmp_valid;
  op_t           start_op, op_q;
  logic [DW-1:0] a_q, b_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i     = rst_sync_q[1];
  assign mem_iaddr = cpu_iaddr;

  ihc_fetch_seq #(.HARDEN_MASK(HARDEN_MASK), .CHK_ADDR(CHK_ADDR)) u_seq (
    .clk(clk), .rst_n(rst_i), .cpu_ifetch(cpu_ifetch), .cpu_iaddr(cpu_iaddr),
    .mem_idata(mem_idata), .cpu_idata(cpu_idata), .start(start),
    .start_op(start_op), .seq_fault(seq_fault)
  );

  ihc_capture #(.DW(DW), .CHK_ADDR(CHK_ADDR)) u_cap (
    .clk(clk), .rst_n(rst_i), .cpu_dwe(cpu_dwe), .cpu_daddr(cpu_daddr),
    .cpu_dwdata(cpu_dwdata), .start(start), .start_op(start_op),
    .mem_dwe(mem_dwe), .mem_daddr(mem_daddr), .mem_dwdata(mem_dwdata),
    .cmp_valid(cmp_valid), .op_q(op_q), .a_q(a_q), .b_q(b_q)
  );

  ihc_alu_cmp #(.DW(DW)) u_cmp (
    .clk(clk), .rst_n(rst_i), .cmp_valid(cmp_valid), .op(op_q), .a(a_q),
    .b(b_q), .res(cpu_dwdata), .seq_fault(seq_fault), .err_q(chk_err),
    .irq_q(chk_irq)
  );

  assert_irq_err_R9: assert property (@(posedge clk) disable iff (!rst_i)
    chk_irq |-> chk_err);
endmodule

// File: tb/tb_fetch_harden_checker.sv
module tb_fetch_harden_checker;
  localparam logic [7:0] CHK = 8'hF0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_ifetch = 1'b0;
  logic [11:0] cpu_iaddr = '0;
  logic [15:0] cpu_idata;
  logic [11:0] mem_iaddr;
  logic [15:0] mem_idata = '0;
  logic        cpu_dwe = 1'b0;
  logic [7:0]  cpu_daddr = '0;
  logic [7:0]  cpu_dwdata = '0;
  logic        mem_dwe;
  logic [7:0]  mem_daddr;
  logic [7:0]  mem_dwdata;
  logic        chk_err, chk_irq;

  int n_checks = 0;
  int n_errs = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fetch_harden_checker dut (
    .clk(clk), .rst_n(rst_n), .cpu_ifetch(cpu_ifetch), .cpu_iaddr(cpu_iaddr),
    .cpu_idata(cpu_idata), .mem_iaddr(mem_iaddr), .mem_idata(mem_idata),
    .cpu_dwe(cpu_dwe), .cpu_daddr(cpu_daddr), .cpu_dwdata(cpu_dwdata),
    .mem_dwe(mem_dwe), .mem_daddr(mem_daddr), .mem_dwdata(mem_dwdata),
    .chk_err(chk_err), .chk_irq(chk_irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cpu_ifetch = 1'b0; cpu_dwe = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic fetch(input logic [11:0] a, input logic [15:0] mw, input logic [15:0] exp, input string req);
    @(negedge clk);
    cpu_dwe = 1'b0; cpu_ifetch = 1'b1; cpu_iaddr = a; mem_idata = mw;
    #1;
    check(cpu_idata === exp, req, cpu_idata, exp);
    check(mem_iaddr === a, "R1 mem_iaddr", mem_iaddr, a);
  endtask

  task automatic dwrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_ifetch = 1'b0; cpu_dwe = 1'b1; cpu_daddr = a; cpu_dwdata = d;
    #1;
    check(mem_dwe === (a != CHK), "R6 mem_dwe", mem_dwe, a != CHK);
    if (a != CHK)
      check(mem_daddr === a && mem_dwdata === d, "R6 pass", {mem_daddr, mem_dwdata}, {a, d});
  endtask

  task automatic idle();
    @(negedge clk);
    cpu_ifetch = 1'b0; cpu_dwe = 1'b0;
    #1;
  endtask

  function automatic logic [7:0] ref_alu(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
    if (op == 4'h1) return a + b;
    return a + 8'd1;
  endfunction

  // Hardened run: five fetches, three checker writes, then error check (R2 R3 R4 R7 R8)
  task automatic hrun(input logic [11:0] a, input logic [15:0] ins, input logic [7:0] x,
                      input logic [7:0] y, input logic [7:0] res, input bit exp_err);
    fetch(a, ins, {4'hE, ins[7:4], CHK}, "R2 slot0");
    fetch(a + 12'd1, 16'h0000, {4'hE, ins[3:0], CHK}, "R3 slot1");
    fetch(a + 12'd2, 16'h5555, ins, "R3 slot2");
    fetch(a + 12'd3, 16'hAAAA, {4'hE, ins[11:8], CHK}, "R3 slot3");
    fetch(a + 12'd4, 16'h1234, {4'hF, a + 12'd1}, "R3 branch");
    dwrite(CHK, x);
    dwrite(CHK, y);
    dwrite(CHK, res);
    idle();
    check(chk_err === exp_err, exp_err ? "R8 mismatch err" : "R7 match no err", chk_err, exp_err);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_errs++; n_checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R11 reset state
    idle();
    check(chk_err === 1'b0, "R11 err", chk_err, 0);
    check(chk_irq === 1'b0, "R11 irq", chk_irq, 0);
    fetch(12'h010, 16'h2345, 16'h2345, "R11 passthrough after reset");

    // R5 / R1: every opcode, hardened or forwarded
    for (int op = 0; op < 16; op++) begin
      logic [15:0] w;
      w = {op[3:0], 4'(op + 1), 4'(op + 2), 4'(op + 5)};
      if (op == 1 || op == 3) begin
        logic [7:0] x, y;
        x = 8'(op * 37); y = 8'(op * 11 + 9);
        hrun(12'h100 + 12'(op * 16), w, x, y, ref_alu(op[3:0], x, y), 1'b0);
        fetch(12'h100 + 12'(op * 16) + 12'd1, 16'h2222, 16'h2222, "R4 resume");
      end else begin
        fetch(12'h300 + 12'(op), w, w, "R5 R1 forward");
      end
    end

    // R6: ordinary write passes through
    dwrite(8'h12, 8'h34);
    dwrite(8'hEF, 8'h01);

    // R7: operand sweep with correct results, ADD and INC incl. wraparound
    for (int i = 0; i < 16; i++) begin
      logic [7:0] x, y;
      x = 8'(i * 17); y = 8'(i * 7 + 250);
      hrun(12'h400 + 12'(i * 8), {4'h1, 4'(i), 4'(i + 3), 4'(i + 6)}, x, y, x + y, 1'b0);
      hrun(12'h600 + 12'(i * 8), {4'h3, 4'(i), 4'(i + 1), 4'(i + 2)}, x, y, x + 8'd1, 1'b0);
    end
    hrun(12'h7F0, 16'h3123, 8'hFF, 8'h00, 8'h00, 1'b0);

    // R8 R9: mismatch sets error, irq one cycle, error stays
    hrun(12'h800, 16'h1456, 8'h10, 8'h20, 8'h31, 1'b1);
    check(chk_irq === 1'b1, "R9 irq pulse", chk_irq, 1);
    idle();
    check(chk_irq === 1'b0, "R9 irq falls", chk_irq, 0);
    hrun(12'h820, 16'h3100, 8'h05, 8'h00, 8'h06, 1'b1);
    check(chk_irq === 1'b0, "R9 no second irq", chk_irq, 0);
    idle();
    check(chk_err === 1'b1, "R8 sticky", chk_err, 1);

    // R11 reset clears, R10 fetch address skip during sequence
    do_reset();
    idle();
    check(chk_err === 1'b0, "R11 err after reset", chk_err, 0);
    fetch(12'h200, 16'h1789, {4'hE, 4'h8, CHK}, "R10 slot0");
    fetch(12'h205, 16'h0000, {4'hE, 4'h9, CHK}, "R10 slot1 on skipped addr");
    idle();
    check(chk_err === 1'b1, "R10 err", chk_err, 1);
    check(chk_irq === 1'b1, "R10 irq", chk_irq, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule